// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block is the control-section sequencer of a microprogrammed processor. It keeps a 9-bit microprogram counter (`upc`) and a 36-bit microinstruction register (`uinstr`). The register is filled from an internal control store of 512 words, addressed by the counter. Each microinstruction names its own successor through a 9-bit address field. Three jump bits change that successor in two ways. One or both of the datapath's negative and zero flags can be ORed into the top address bit, so a taken branch lands 0x100 above the untaken one. An opcode byte can also be ORed into the low eight bits, which gives multiway dispatch to the microcode routine of an instruction.

The counter advances on the rising clock edge. The microinstruction register loads on the falling edge from the word the counter points at. The control fields for the datapath (ALU/shift control, C-bus write mask, memory control, B-bus source) come out as separate ports. The control store is written through a synchronous write port, normally while reset is held. A two-state controller gates stepping. In HOLD the counter is frozen. In STEP it advances on every edge at which `step_en` is high.

States and transitions: reset enters HOLD. HOLD goes to STEP on an edge where `step_en` is 1, and that edge does not advance the counter. STEP stays in STEP while `step_en` is 1, advancing on each edge. STEP goes back to HOLD on an edge where `step_en` is 0, and that edge does not advance the counter.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high, `upc` is 0x000, `uinstr` is all zeros and `running` is 0. The first counter value after reset is 0x000.
- R2: When all three jump bits are 0, the next `upc` equals the 9-bit address field `uinstr[35:27]`.
- R3: With JAMZ (`uinstr[24]`) set, the next `upc[8]` is 1 when `alu_z` is 1. When `alu_z` is 0, `upc[8]` equals address bit 8. `alu_n` has no effect on a JAMZ-only word.
- R4: With JAMN (`uinstr[25]`) set, the next `upc[8]` is 1 when `alu_n` is 1. When `alu_n` is 0, `upc[8]` equals address bit 8. `alu_z` has no effect on a JAMN-only word.
- R5: When address bit 8 (`uinstr[35]`) is 1, the next `upc[8]` is 1 whatever the flags are.
- R6: With JMPC (`uinstr[26]`) set, the next `upc[7:0]` is `uinstr[34:27] | opbyte`. For example, opbyte 0x10 with address field 0x000 gives 0x010.
- R7: With JMPC clear, `opbyte` has no effect: the next `upc[7:0]` equals `uinstr[34:27]`.
- R8: `uinstr` changes only on falling edges, where it takes the store word at the current `upc`. Just after a rising edge that moves `upc`, `uinstr` still holds the previous word.
- R9: `alu_ctl` = `uinstr[23:16]`, `c_mask` = `uinstr[15:7]`, `mem_ctl` = `uinstr[6:4]`, `b_sel` = `uinstr[3:0]`.
- R10: The counter advances only on an edge where the state is STEP and `step_en` is 1. The edge that enters STEP and the edge that leaves it both keep `upc` unchanged. `running` is 1 exactly in STEP.
- R11: A store write (`store_we` with address and data) takes effect at the rising edge. If `upc` addresses the written word, the new word appears on `uinstr` at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counter on rising edge, microinstruction register on falling edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Request to step the microprogram |
| store_we | input | 1 | Control-store write enable |
| store_waddr | input | 9 | Control-store write address |
| store_wdata | input | 36 | Control-store write word |
| alu_n | input | 1 | Negative flag from the datapath, sampled at the rising edge |
| alu_z | input | 1 | Zero flag from the datapath, sampled at the rising edge |
| opbyte | input | 8 | Opcode byte used for dispatch |
| running | output | 1 | Controller is in STEP |
| upc | output | 9 | Microprogram counter |
| uinstr | output | 36 | Current microinstruction |
| alu_ctl | output | 8 | ALU/shift control field |
| c_mask | output | 9 | C-bus register write mask |
| mem_ctl | output | 3 | Memory operation field |
| b_sel | output | 4 | B-bus source select |

## Verification
Flags and opcode driven after a rising edge are used at the next rising edge. The new `upc` is due right after that edge, and the matching `uinstr` and control fields are due only after the falling edge that follows. Each expected item is queued with the cycle count at which it is due. The monitor compares it 2 ns after that cycle's falling edge, when both the counter and the register have settled. One extra probe samples 2 ns after a rising edge, which confirms that `upc` has moved while `uinstr` still shows the old word. The first step after HOLD is queued with an unchanged counter, because the entering edge does not advance.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
    localparam int ADDR_W  = 9;
    localparam int BYTE_W  = 8;
    localparam int ALU_W   = 8;
    localparam int CMASK_W = 9;
    localparam int MEM_W   = 3;
    localparam int BSEL_W  = 4;
    localparam int JAM_W   = 3;
    localparam int WORD_W  = ADDR_W + JAM_W + ALU_W + CMASK_W + MEM_W + BSEL_W;

    // Microinstruction layout, most significant field first.
    typedef struct packed {
        logic [ADDR_W-1:0]  nxt;
        logic               jmpc;
        logic               jamn;
        logic               jamz;
        logic [ALU_W-1:0]   alu;
        logic [CMASK_W-1:0] cmask;
        logic [MEM_W-1:0]   mem;
        logic [BSEL_W-1:0]  bsel;
    } uword_t;

    typedef enum logic {
        SEQ_HOLD = 1'b0,
        SEQ_STEP = 1'b1
    } seq_state_e;
endpackage

// File: rtl/useq_store.sv
`timescale 1ns/1ps
module useq_store #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Combinational read; the microinstruction register samples it.
    assign rdata = cells[raddr];
endmodule

// File: rtl/useq_next.sv
`timescale 1ns/1ps
module useq_next #(
    parameter int ADDR_W = 9,
    parameter int BYTE_W = 8
) (
    input  logic [ADDR_W-1:0] field_addr,
    input  logic              jmpc,
    input  logic              jamn,
    input  logic              jamz,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int LOW_W = ADDR_W - 1;

    logic             high_bit;
    logic [LOW_W-1:0] low_bits;

    // Branch: a selected flag forces the top bit, giving field + 0x100.
    always_comb begin
        high_bit = field_addr[ADDR_W-1] | (jamz & flag_z) | (jamn & flag_n);
    end

    // Dispatch: the opcode byte is merged into the low bits.
    always_comb begin
        low_bits = field_addr[LOW_W-1:0];
        if (jmpc) begin
            low_bits = low_bits | LOW_W'(byte_in);
        end
    end

    assign next_addr = {high_bit, low_bits};
endmodule

// File: rtl/useq_fsm.sv
`timescale 1ns/1ps
module useq_fsm
    import useq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step_en,
    output seq_state_e state_q,
    output logic       advance
);
    seq_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_HOLD: if (step_en)  state_d = SEQ_STEP;
            SEQ_STEP: if (!step_en) state_d = SEQ_HOLD;
        endcase
    end

    // Outputs: only STEP with a live request moves the counter.
    always_comb begin
        advance = 1'b0;
        unique case (state_q)
            SEQ_HOLD: advance = 1'b0;
            SEQ_STEP: advance = step_en;
        endcase
    end
endmodule

// File: rtl/useq_sequencer.sv
`timescale 1ns/1ps
module useq_sequencer
    import useq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic               store_we,
    input  logic [ADDR_W-1:0]  store_waddr,
    input  logic [WORD_W-1:0]  store_wdata,
    input  logic               alu_n,
    input  logic               alu_z,
    input  logic [BYTE_W-1:0]  opbyte,
    output logic               running,
    output logic [ADDR_W-1:0]  upc,
    output logic [WORD_W-1:0]  uinstr,
    output logic [ALU_W-1:0]   alu_ctl,
    output logic [CMASK_W-1:0] c_mask,
    output logic [MEM_W-1:0]   mem_ctl,
    output logic [BSEL_W-1:0]  b_sel
);
    seq_state_e        st;
    logic              advance;
    logic [ADDR_W-1:0] mpc_q;
    logic [ADDR_W-1:0] mpc_d;
    logic [WORD_W-1:0] rd_word;
    uword_t            mir_q;

    useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (store_waddr),
        .wdata (store_wdata),
        .raddr (mpc_q),
        .rdata (rd_word)
    );

    useq_next #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_next (
        .field_addr (mir_q.nxt),
        .jmpc       (mir_q.jmpc),
        .jamn       (mir_q.jamn),
        .jamz       (mir_q.jamz),
        .flag_n     (alu_n),
        .flag_z     (alu_z),
        .byte_in    (opbyte),
        .next_addr  (mpc_d)
    );

    useq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .state_q (st),
        .advance (advance)
    );

    // Counter: rising edge; the flags are captured here with the address.
    always_ff @(posedge clk) begin
        if (rst) begin
            mpc_q <= '0;
        end else if (advance) begin
            mpc_q <= mpc_d;
        end
    end

    // Microinstruction register: falling edge, from the counter's word.
    always_ff @(negedge clk) begin
        if (rst) begin
            mir_q <= '0;
        end else begin
            mir_q <= uword_t'(rd_word);
        end
    end

    assign running = (st == SEQ_STEP);
    assign upc     = mpc_q;
    assign uinstr  = mir_q;
    assign alu_ctl = mir_q.alu;
    assign c_mask  = mir_q.cmask;
    assign mem_ctl = mir_q.mem;
    assign b_sel   = mir_q.bsel;
endmodule

module useq_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic        step_en,
    input logic        running,
    input logic        alu_n,
    input logic        alu_z,
    input logic [7:0]  opbyte,
    input logic [8:0]  upc,
    input logic [11:0] ctl_hi
);
    // ctl_hi: [11:3] address field, [2] JMPC, [1] JAMN, [0] JAMZ
    logic live;
    assign live = running && step_en;

    a_r10_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (!running || !step_en) |=> $stable(upc));

    a_r2_plain_next: assert property (@(posedge clk) disable iff (rst)
        (live && ctl_hi[2:0] == 3'b000) |=> (upc == $past(ctl_hi[11:3])));

    a_r3_jamz_taken: assert property (@(posedge clk) disable iff (rst)
        (live && ctl_hi[0] && alu_z) |=> upc[8]);

    a_r4_jamn_taken: assert property (@(posedge clk) disable iff (rst)
        (live && ctl_hi[1] && alu_n) |=> upc[8]);

    a_r5_high_sticky: assert property (@(posedge clk) disable iff (rst)
        (live && ctl_hi[11]) |=> upc[8]);

    a_r6_dispatch_low: assert property (@(posedge clk) disable iff (rst)
        (live && ctl_hi[2]) |=> (upc[7:0] == ($past(ctl_hi[10:3]) | $past(opbyte))));

    a_r7_byte_ignored: assert property (@(posedge clk) disable iff (rst)
        (live && !ctl_hi[2]) |=> (upc[7:0] == $past(ctl_hi[10:3])));
endmodule

bind useq_sequencer useq_sequencer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .running (running),
    .alu_n   (alu_n),
    .alu_z   (alu_z),
    .opbyte  (opbyte),
    .upc     (upc),
    .ctl_hi  (uinstr[35:24])
);

// File: tb/sim_useq_sequencer.sv
`timescale 1ns/1ps
module sim_useq_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic        store_we = 1'b0;
    logic [8:0]  store_waddr = '0;
    logic [35:0] store_wdata = '0;
    logic        alu_n = 1'b0;
    logic        alu_z = 1'b0;
    logic [7:0]  opbyte = '0;
    logic        running;
    logic [8:0]  upc;
    logic [35:0] uinstr;
    logic [7:0]  alu_ctl;
    logic [8:0]  c_mask;
    logic [2:0]  mem_ctl;
    logic [3:0]  b_sel;

    useq_sequencer u0 (
        .clk(clk), .rst(rst), .step_en(step_en), .store_we(store_we),
        .store_waddr(store_waddr), .store_wdata(store_wdata),
        .alu_n(alu_n), .alu_z(alu_z), .opbyte(opbyte), .running(running),
        .upc(upc), .uinstr(uinstr), .alu_ctl(alu_ctl), .c_mask(c_mask),
        .mem_ctl(mem_ctl), .b_sel(b_sel)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int          due;
        logic [8:0]  pc;
        logic [35:0] word;
        logic        run;
        string       req;
    } exp_t;

    exp_t        sbq[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;
    logic [35:0] rom_m [512];
    logic [8:0]  cur_upc;
    logic        armed;

    always @(posedge clk) cyc <= cyc + 1;

    // R9 layout: addr[35:27] jmpc[26] jamn[25] jamz[24] alu[23:16] cmask[15:7] mem[6:4] b[3:0]
    function automatic logic [35:0] mk(input logic [8:0] a, input logic j, input logic n,
                                       input logic z, input logic [7:0] al,
                                       input logic [8:0] cm, input logic [2:0] me,
                                       input logic [3:0] bs);
        return {a, j, n, z, al, cm, me, bs};
    endfunction

    // Successor rule from R2..R7
    function automatic logic [8:0] succ(input logic [35:0] w, input logic n,
                                        input logic z, input logic [7:0] b);
        logic       hi;
        logic [7:0] lo;
        hi = w[35] | (w[24] & z) | (w[25] & n);
        lo = w[34:27] | (w[26] ? b : 8'h00);
        return {hi, lo};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pops items due this cycle, 2 ns after the falling edge.
    always @(negedge clk) begin
        #2;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.req, "due cycle", 36'(e.due), 36'(cyc));
            chk(e.req, "upc", 36'(upc), 36'(e.pc));
            chk(e.req, "uinstr", uinstr, e.word);
            chk("R9", "fields", {alu_ctl, c_mask, mem_ctl, b_sel}, {8'h0, e.word[23:0]});
            chk("R10", "running", 36'(running), 36'(e.run));
        end
    end

    task automatic push(input string req);
        exp_t e;
        e.due  = cyc + 1;
        e.pc   = cur_upc;
        e.word = rom_m[cur_upc];
        e.run  = step_en;
        e.req  = req;
        sbq.push_back(e);
    endtask

    task automatic step(input logic n, input logic z, input logic [7:0] b, input string req);
        @(posedge clk); #1;
        step_en = 1'b1; store_we = 1'b0;
        alu_n = n; alu_z = z; opbyte = b;
        if (!armed) armed = 1'b1;          // R10: entering edge does not advance
        else cur_upc = succ(rom_m[cur_upc], n, z, b);
        push(req);
    endtask

    task automatic hold(input logic we, input logic [8:0] wa, input logic [35:0] wd,
                        input string req);
        @(posedge clk); #1;
        step_en = 1'b0; store_we = we; store_waddr = wa; store_wdata = wd;
        alu_n = 1'b1; alu_z = 1'b1; opbyte = 8'hFF;
        if (we) rom_m[wa] = wd;
        armed = 1'b0;
        push(req);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [35:0] old_w;
        logic [8:0]  mid_pc;
        for (int i = 0; i < 512; i++) rom_m[i] = '0;
        rom_m[9'h000] = mk(9'h001, 0, 0, 0, 8'hA5, 9'h1F3, 3'd5, 4'h9);
        rom_m[9'h001] = mk(9'h002, 0, 0, 1, 8'h11, 9'h001, 3'd1, 4'h1);
        rom_m[9'h002] = mk(9'h001, 0, 0, 1, 8'h22, 9'h002, 3'd2, 4'h2);
        rom_m[9'h101] = mk(9'h005, 0, 1, 0, 8'h33, 9'h100, 3'd3, 4'h3);
        rom_m[9'h005] = mk(9'h006, 0, 1, 0, 8'h44, 9'h0F0, 3'd4, 4'h4);
        rom_m[9'h106] = mk(9'h007, 0, 0, 1, 8'h55, 9'h00F, 3'd6, 4'h5);
        rom_m[9'h007] = mk(9'h180, 0, 0, 0, 8'h66, 9'h155, 3'd7, 4'h6);
        rom_m[9'h180] = mk(9'h120, 0, 0, 1, 8'h77, 9'h0AA, 3'd0, 4'h7);
        rom_m[9'h120] = mk(9'h000, 1, 0, 0, 8'h88, 9'h1FF, 3'd1, 4'h8);
        rom_m[9'h010] = mk(9'h100, 1, 0, 0, 8'h99, 9'h123, 3'd2, 4'hA);
        rom_m[9'h14C] = mk(9'h0F3, 1, 1, 1, 8'hCC, 9'h0C3, 3'd3, 4'hB);
        rom_m[9'h1FF] = mk(9'h000, 0, 0, 0, 8'hEE, 9'h1E1, 3'd4, 4'hC);

        // Load the store while reset is held (R11 write port)
        for (int i = 0; i < 512; i++) begin
            @(posedge clk); #1;
            store_we = 1'b1; store_waddr = 9'(i); store_wdata = rom_m[i];
        end
        @(posedge clk); #1;
        store_we = 1'b0;

        // R1: reset state
        @(negedge clk); #2;
        chk("R1", "upc in reset", 36'(upc), 36'h0);
        chk("R1", "uinstr in reset", uinstr, 36'h0);
        chk("R1", "running in reset", 36'(running), 36'h0);

        @(posedge clk); #1;
        rst = 1'b0;
        cur_upc = '0;
        armed = 1'b0;
        push("R1");

        step(0, 0, 8'h00, "R10");          // enter STEP, no advance
        old_w = rom_m[cur_upc];
        step(0, 0, 8'h00, "R2");           // 000 -> 001
        mid_pc = cur_upc;
        step(0, 0, 8'h00, "R3");           // JAMZ, Z=0 -> 002
        #1;
        chk("R8", "upc after rise", 36'(upc), 36'(mid_pc));
        chk("R8", "uinstr before fall", uinstr, old_w);
        step(0, 1, 8'h00, "R3");           // JAMZ, Z=1 -> 101
        step(0, 1, 8'h00, "R4");           // JAMN, N=0 Z=1 -> 005
        step(1, 0, 8'h00, "R4");           // JAMN, N=1 -> 106
        step(1, 0, 8'h00, "R3");           // JAMZ, N=1 Z=0 -> 007
        step(1, 1, 8'hFF, "R7");           // plain, byte ignored -> 180
        step(0, 0, 8'h00, "R5");           // top bit set, Z=0 -> 120
        step(0, 0, 8'h10, "R6");           // dispatch 0x10 -> 010
        step(0, 0, 8'h4C, "R6");           // 0x100 | 0x4C -> 14C
        step(1, 0, 8'h0C, "R6");           // all jumps, N=1 -> 1FF
        step(0, 0, 8'h00, "R2");           // -> 000
        hold(0, 9'h0, 36'h0, "R10");       // leaving edge: no advance
        hold(0, 9'h0, 36'h0, "R10");       // held, flags toggling ignored
        hold(1, 9'h000, mk(9'h0AA, 0, 0, 0, 8'h5A, 9'h05A, 3'd5, 4'hD), "R11");
        hold(0, 9'h0, 36'h0, "R11");
        step(0, 0, 8'h00, "R10");          // re-enter, no advance
        step(0, 0, 8'h00, "R2");           // new word -> 0AA
        step(0, 0, 8'h00, "R2");           // zero word -> 000

        repeat (3) @(negedge clk);
        #3;
        chk("R10", "scoreboard drained", 36'(sbq.size()), 36'h0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule